// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that a 16-bit real-mode processor core uses to enter and leave interrupt handlers. At every instruction boundary it weighs the interrupt sources that are pending and picks one by a fixed priority. It then saves the machine state on the stack through a single word-wide memory handshake and fetches the handler's address from the vector table at the bottom of physical memory. The candidate sources are an internal fault (divide error is type 0, the overflow trap is type 4), a software interrupt carrying its own type, an external request that the interrupt-enable flag gates, and the single-step trap of type 1 that the trace flag raises.

On entry the sequencer saves the original FLAGS, then clears the trace and interrupt-enable bits, then saves CS and then IP. It then reads the new IP from the word at type*4 and the new CS from type*4+2. A return request undoes this in the reverse order: it restores IP, then CS, then FLAGS. After an instruction that loaded the stack segment, only faults are accepted at the next boundary, so that the stack pointer can be loaded without a break in between. The core presents its registers on the inputs when a sequence starts. It takes the updated registers from the outputs once the completion pulse appears.

Top module: `int_entry_seq`

## Requirements
- R1: While reset is low and right after it, `busy`, `memReq`, `seqDone` and `extAck` are 0, and the register outputs read 0.
- R2: An entry performs exactly five accesses in this order: a write at SS*16+SP-2, a write at SS*16+SP-4, a write at SS*16+SP-6 (holding FLAGS, CS and IP in that order, with 20-bit wrap), then a read at type*4 and a read at type*4+2. After it `spOut` equals SP-6 modulo 2^16.
- R3: The FLAGS word that is written is the value before any change. `flagsOut` after entry equals that value with bit 8 (trace) and bit 9 (interrupt enable) cleared and all other bits kept.
- R4: After entry `ipOut` holds the word read at type*4 and `csOut` holds the word read at type*4+2. `seqDone` is high for exactly one cycle per sequence, and `busy` is low again in that cycle.
- R5: A return reads SS*16+SP, SS*16+SP+2 and SS*16+SP+4 into IP, CS and FLAGS in that order. It leaves `spOut` at SP+6.
- R6: Pending sources are evaluated only in a cycle where `instrDone` is high while the block is idle. Without that strobe, no sequence starts.
- R7: When several sources are pending, the priority is: fault (`faultType`), then software (`swType`), then external (`extType`), then single-step (type 1).
- R8: The external request is taken only when FLAGS bit 9 is 1. `extAck` pulses once, one cycle after the boundary, only when the external request is the one chosen.
- R9: When `ssWrite` is high at the boundary, software, external and single-step sources are ignored, and a fault is still taken.
- R10: FLAGS bit 8 set at a boundary with no higher source pending starts an entry with type 1.
- R11: While `memReq` is high and `memAck` is low, the request, direction, address and write data are held and the sequence does not advance. Each access completes exactly once whatever the stall length.
- R12: `retReq` is taken only when the block is idle and `instrDone` is low. If `instrDone` is high in the same cycle, the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Current instruction has completed (boundary strobe) |
| ssWrite | input | 1 | The completing instruction loaded the stack segment |
| faultReq | input | 1 | Internal fault pending |
| faultType | input | 8 | Type code of the fault |
| swReq | input | 1 | Software interrupt instruction pending |
| swType | input | 8 | Type code supplied by the instruction |
| extReq | input | 1 | External interrupt request |
| extType | input | 8 | Type code supplied by the external controller |
| retReq | input | 1 | Interrupt return requested |
| flagsIn | input | 16 | Current FLAGS |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Current instruction pointer (return address) |
| ssIn | input | 16 | Current stack segment |
| spIn | input | 16 | Current stack pointer |
| memAck | input | 1 | Memory access complete |
| memRData | input | 16 | Read data, valid with memAck |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | 20 | Physical byte address of the word |
| memWData | output | 16 | Write data |
| busy | output | 1 | A sequence is in progress |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |
| extAck | output | 1 | One-cycle pulse when the external request is accepted |
| entryType | output | 8 | Type code of the latest entry |
| flagsOut | output | 16 | FLAGS after the sequence |
| csOut | output | 16 | CS after the sequence |
| ipOut | output | 16 | IP after the sequence |
| spOut | output | 16 | SP after the sequence |

## Verification
The arbitration is the part where functions meet in one cycle. A fault, a software interrupt, an enabled external request and the trace flag can all be active at the same boundary, and the stack-segment shadow can be active at the same time as any of them. The bench drives these combinations from a table in a single `instrDone` cycle. It judges the winner by the type on `entryType`, by the vector words that land in `ipOut` and `csOut`, and by whether `extAck` fired. A second meeting point is a return request that arrives in the same cycle as a boundary strobe. The bench judges it by the absence of any memory request afterwards.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;
  localparam int WORD_W = 16;
  localparam int PHYS_W = 20;
  localparam int TYPE_W = 8;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSHF, S_PUSHCS, S_PUSHIP, S_RDIP, S_RDCS, S_POPIP, S_POPCS, S_POPF
  } seqState_e;

  typedef enum logic [1:0] {ADR_PUSH, ADR_POP, ADR_VEC_IP, ADR_VEC_CS} adrSel_e;
  typedef enum logic [1:0] {WD_FLAGS, WD_CS, WD_IP} wdSel_e;

  typedef struct packed {
    logic    load;
    logic    spDec;
    logic    spInc;
    logic    clrMask;
    logic    ldIp;
    logic    ldCs;
    logic    ldFlags;
    adrSel_e adrSel;
    wdSel_e  wdSel;
  } dpCtl_t;
endpackage

// File: rtl/int_seq_ctrl.sv
module int_seq_ctrl
  import int_seq_pkg::*;
#(
  parameter int TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instrDone,
  input  logic          ssWrite,
  input  logic          faultReq,
  input  logic [TW-1:0] faultType,
  input  logic          swReq,
  input  logic [TW-1:0] swType,
  input  logic          extReq,
  input  logic [TW-1:0] extType,
  input  logic          retReq,
  input  logic          tfIn,
  input  logic          ifIn,
  input  logic          memAck,
  output dpCtl_t        ctl,
  output logic [TW-1:0] nextType,
  output logic          memReq,
  output logic          memWe,
  output logic          busy,
  output logic          seqDone,
  output logic          extAck
);
  localparam logic [TW-1:0] TRACE_TYPE = TW'(1);

  seqState_e state, stateNx;
  logic idle, takeFault, takeSw, takeExt, takeTrace;
  logic startEntry, startRet, extWins;

  always_comb begin
    idle      = (state == S_IDLE);
    takeFault = faultReq;
    takeSw    = swReq && !ssWrite;
    takeExt   = extReq && ifIn && !ssWrite;
    takeTrace = tfIn && !ssWrite;
    extWins   = !takeFault && !takeSw && takeExt;
    if (takeFault)    nextType = faultType;
    else if (takeSw)  nextType = swType;
    else if (takeExt) nextType = extType;
    else              nextType = TRACE_TYPE;
    startEntry = idle && instrDone && (takeFault || takeSw || takeExt || takeTrace);
    startRet   = idle && !instrDone && retReq;
  end

  always_comb begin
    ctl      = '0;
    ctl.load = startEntry || startRet;
    stateNx  = state;
    case (state)
      S_IDLE: begin
        if (startEntry)    stateNx = S_PUSHF;
        else if (startRet) stateNx = S_POPIP;
      end
      S_PUSHF: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_FLAGS;
        if (memAck) begin ctl.spDec = 1'b1; ctl.clrMask = 1'b1; stateNx = S_PUSHCS; end
      end
      S_PUSHCS: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_CS;
        if (memAck) begin ctl.spDec = 1'b1; stateNx = S_PUSHIP; end
      end
      S_PUSHIP: begin
        ctl.adrSel = ADR_PUSH; ctl.wdSel = WD_IP;
        if (memAck) begin ctl.spDec = 1'b1; stateNx = S_RDIP; end
      end
      S_RDIP: begin
        ctl.adrSel = ADR_VEC_IP;
        if (memAck) begin ctl.ldIp = 1'b1; stateNx = S_RDCS; end
      end
      S_RDCS: begin
        ctl.adrSel = ADR_VEC_CS;
        if (memAck) begin ctl.ldCs = 1'b1; stateNx = S_IDLE; end
      end
      S_POPIP: begin
        ctl.adrSel = ADR_POP;
        if (memAck) begin ctl.ldIp = 1'b1; ctl.spInc = 1'b1; stateNx = S_POPCS; end
      end
      S_POPCS: begin
        ctl.adrSel = ADR_POP;
        if (memAck) begin ctl.ldCs = 1'b1; ctl.spInc = 1'b1; stateNx = S_POPF; end
      end
      S_POPF: begin
        ctl.adrSel = ADR_POP;
        if (memAck) begin ctl.ldFlags = 1'b1; ctl.spInc = 1'b1; stateNx = S_IDLE; end
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      seqDone <= 1'b0;
      extAck  <= 1'b0;
    end else begin
      state   <= stateNx;
      seqDone <= memAck && (state == S_RDCS || state == S_POPF);
      extAck  <= startEntry && extWins;
    end
  end

  assign memReq = !idle;
  assign memWe  = (state == S_PUSHF) || (state == S_PUSHCS) || (state == S_PUSHIP);
  assign busy   = !idle;

  // R6
  no_stray_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !instrDone && !retReq) |=> !busy);
  // R9
  shadow_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && instrDone && ssWrite && !faultReq) |=> !busy);
  // R8
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    extAck |-> ($past(ifIn) && $past(extReq)));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);
  // R4
  done_on_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> seqDone);
endmodule

// File: rtl/int_seq_dp.sv
module int_seq_dp
  import int_seq_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int PW = PHYS_W,
  parameter int TW = TYPE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [TW-1:0] nextType,
  input  logic [WW-1:0] flagsIn,
  input  logic [WW-1:0] csIn,
  input  logic [WW-1:0] ipIn,
  input  logic [WW-1:0] ssIn,
  input  logic [WW-1:0] spIn,
  input  logic [WW-1:0] memRData,
  output logic [PW-1:0] memAddr,
  output logic [WW-1:0] memWData,
  output logic [TW-1:0] entryType,
  output logic [WW-1:0] flagsOut,
  output logic [WW-1:0] csOut,
  output logic [WW-1:0] ipOut,
  output logic [WW-1:0] spOut
);
  localparam int SEG_SHIFT = PW - WW;
  localparam int VEC_PAD   = PW - TW - 2;
  localparam logic [WW-1:0] WORD_BYTES = WW'(2);

  logic [WW-1:0] flagsR, csR, ipR, spR, ssR;
  logic [TW-1:0] typeR;
  logic [PW-1:0] stackBase;
  logic [WW-1:0] spDn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsR <= '0; csR <= '0; ipR <= '0; spR <= '0; ssR <= '0; typeR <= '0;
    end else if (ctl.load) begin
      flagsR <= flagsIn; csR <= csIn; ipR <= ipIn; spR <= spIn; ssR <= ssIn;
      typeR  <= nextType;
    end else begin
      if (ctl.spDec) spR <= spR - WORD_BYTES;
      if (ctl.spInc) spR <= spR + WORD_BYTES;
      if (ctl.clrMask) begin
        flagsR[TF_POS] <= 1'b0;
        flagsR[IF_POS] <= 1'b0;
      end
      if (ctl.ldFlags) flagsR <= memRData;
      if (ctl.ldIp)    ipR    <= memRData;
      if (ctl.ldCs)    csR    <= memRData;
    end
  end

  always_comb begin
    stackBase = {ssR, {SEG_SHIFT{1'b0}}};
    spDn      = spR - WORD_BYTES;
    case (ctl.adrSel)
      ADR_PUSH:   memAddr = stackBase + {{SEG_SHIFT{1'b0}}, spDn};
      ADR_POP:    memAddr = stackBase + {{SEG_SHIFT{1'b0}}, spR};
      ADR_VEC_IP: memAddr = {{VEC_PAD{1'b0}}, typeR, 2'b00};
      default:    memAddr = {{VEC_PAD{1'b0}}, typeR, 2'b10};
    endcase
    case (ctl.wdSel)
      WD_FLAGS: memWData = flagsR;
      WD_CS:    memWData = csR;
      default:  memWData = ipR;
    endcase
  end

  assign entryType = typeR;
  assign flagsOut  = flagsR;
  assign csOut     = csR;
  assign ipOut     = ipR;
  assign spOut     = spR;

  // R3
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldCs && ctl.adrSel == ADR_VEC_CS) |-> (!flagsR[TF_POS] && !flagsR[IF_POS]));
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrDone,
  input  logic              ssWrite,
  input  logic              faultReq,
  input  logic [TYPE_W-1:0] faultType,
  input  logic              swReq,
  input  logic [TYPE_W-1:0] swType,
  input  logic              extReq,
  input  logic [TYPE_W-1:0] extType,
  input  logic              retReq,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRData,
  output logic              memReq,
  output logic              memWe,
  output logic [PHYS_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              busy,
  output logic              seqDone,
  output logic              extAck,
  output logic [TYPE_W-1:0] entryType,
  output logic [WORD_W-1:0] flagsOut,
  output logic [WORD_W-1:0] csOut,
  output logic [WORD_W-1:0] ipOut,
  output logic [WORD_W-1:0] spOut
);
  dpCtl_t ctl;
  logic [TYPE_W-1:0] nextType;

  int_seq_ctrl #(.TW(TYPE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .ssWrite(ssWrite),
    .faultReq(faultReq), .faultType(faultType), .swReq(swReq), .swType(swType),
    .extReq(extReq), .extType(extType), .retReq(retReq),
    .tfIn(flagsIn[TF_POS]), .ifIn(flagsIn[IF_POS]), .memAck(memAck),
    .ctl(ctl), .nextType(nextType), .memReq(memReq), .memWe(memWe),
    .busy(busy), .seqDone(seqDone), .extAck(extAck)
  );

  int_seq_dp #(.WW(WORD_W), .PW(PHYS_W), .TW(TYPE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nextType(nextType),
    .flagsIn(flagsIn), .csIn(csIn), .ipIn(ipIn), .ssIn(ssIn), .spIn(spIn),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData),
    .entryType(entryType), .flagsOut(flagsOut), .csOut(csOut),
    .ipOut(ipOut), .spOut(spOut)
  );

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWData)));
endmodule

// File: tb/sim_int_entry_seq.sv
module sim_int_entry_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] BASE_CS = 16'h3456, BASE_IP = 16'h789A;
  localparam logic [15:0] BASE_SS = 16'h1000, BASE_SP = 16'h0100;

  typedef struct packed {
    logic f; logic [7:0] fT; logic s; logic [7:0] sT; logic e; logic [7:0] eT;
    logic sh; logic [15:0] fl; logic take; logic [7:0] expT; logic ack;
  } vec_t;

  // fault, type, sw, type, ext, type, ssShadow, flags, taken, expected type, extAck
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 1'b1, 8'h00, 1'b0},
    '{1'b1, 8'h04, 1'b1, 8'h21, 1'b1, 8'h08, 1'b0, 16'h0300, 1'b1, 8'h04, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h21, 1'b1, 8'h08, 1'b0, 16'h0300, 1'b1, 8'h21, 1'b0},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 16'h0385, 1'b1, 8'h08, 1'b1},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 16'h0100, 1'b1, 8'h01, 1'b0},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h08, 1'b0, 16'h00C1, 1'b0, 8'h00, 1'b0},
    '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'hF1FF, 1'b1, 8'h01, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h21, 1'b1, 8'h08, 1'b1, 16'h0300, 1'b0, 8'h00, 1'b0},
    '{1'b1, 8'h00, 1'b1, 8'h21, 1'b0, 8'h00, 1'b1, 16'h0200, 1'b1, 8'h00, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 16'h0001, 1'b1, 8'hFF, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic instrDone = 0, ssWrite = 0, faultReq = 0, swReq = 0, extReq = 0, retReq = 0;
  logic [7:0] faultType = 0, swType = 0, extType = 0;
  logic [15:0] flagsIn = 0, csIn = 0, ipIn = 0, ssIn = 0, spIn = 0;
  logic memAck = 0;
  logic [15:0] memRData = 0;
  logic memReq, memWe, busy, seqDone, extAck;
  logic [19:0] memAddr;
  logic [15:0] memWData, flagsOut, csOut, ipOut, spOut;
  logic [7:0] entryType;

  int nChecks = 0, nErr = 0, stallCycles = 0, waitCnt = 0;
  int logCnt = 0, extAckCnt = 0, doneCnt = 0, reqCycles = 0;
  logic [19:0] logAddr [16];
  logic [15:0] logData [16];
  logic        logWe   [16];
  logic [15:0] ram [logic [19:0]];

  int_entry_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] vecWord(input logic [19:0] a);
    return 16'h8000 | a[15:0];
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (memReq && memAck) begin
        if (memWe) ram[memAddr] = memWData;
        if (logCnt < 16) begin
          logAddr[logCnt] = memAddr;
          logWe[logCnt]   = memWe;
          logData[logCnt] = memWe ? memWData : memRData;
        end
        logCnt++;
      end
      if (extAck)  extAckCnt++;
      if (seqDone) doneCnt++;
      if (memReq)  reqCycles++;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin memAck <= 1'b0; waitCnt <= 0; end
    else if (memAck) memAck <= 1'b0;
    else if (memReq) begin
      if (waitCnt >= stallCycles) begin
        memAck   <= 1'b1;
        waitCnt  <= 0;
        memRData <= ram.exists(memAddr) ? ram[memAddr] : vecWord(memAddr);
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logCnt = 0; extAckCnt = 0; doneCnt = 0; reqCycles = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 200 && doneCnt == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseBoundary(input vec_t v);
    @(negedge clk);
    faultReq = v.f; faultType = v.fT; swReq = v.s; swType = v.sT;
    extReq = v.e; extType = v.eT; ssWrite = v.sh; flagsIn = v.fl;
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 0; faultReq = 0; swReq = 0; extReq = 0; ssWrite = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    csIn = BASE_CS; ipIn = BASE_IP; ssIn = BASE_SS; spIn = BASE_SP;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 memReq", memReq, 0);
    check("R1 ipOut", ipOut, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy, seqDone, extAck, memReq}, 0);
    check("R1 spOut", spOut, 0);

    // Table walk: R7 priority, R8 gate, R9 shadow, R10 trace, R4 vector load
    for (int k = 0; k < NV; k++) begin
      clearLog();
      pulseBoundary(VECS[k]);
      if (VECS[k].take) begin
        waitDone();
        check($sformatf("R7 type vec%0d", k), entryType, VECS[k].expT);
        check($sformatf("R8 extAck vec%0d", k), extAckCnt, VECS[k].ack);
        check($sformatf("R4 ip vec%0d", k), ipOut, vecWord({10'd0, VECS[k].expT, 2'b00}));
        check($sformatf("R4 cs vec%0d", k), csOut, vecWord({10'd0, VECS[k].expT, 2'b10}));
        check($sformatf("R3 flags vec%0d", k), flagsOut, VECS[k].fl & 16'hFCFF);
        check($sformatf("R3 pushed vec%0d", k), logData[0], VECS[k].fl);
        check($sformatf("R4 done vec%0d", k), {doneCnt[3:0], busy}, 5'b00010);
      end else begin
        repeat (6) @(negedge clk);
        check($sformatf("R9 no entry vec%0d", k), reqCycles, 0);
        check($sformatf("R8 no ack vec%0d", k), extAckCnt, 0);
      end
    end

    // R6: pending sources without a boundary strobe
    clearLog();
    @(negedge clk); swReq = 1; swType = 8'h33; faultReq = 1; flagsIn = 16'h0300;
    repeat (5) @(negedge clk);
    swReq = 0; faultReq = 0;
    check("R6 no boundary", reqCycles, 0);

    // R2, R11: entry with stack wrap and stalled memory
    clearLog(); ram.delete(); stallCycles = 3;
    ssIn = 16'h2000; spIn = 16'h0000;
    pulseBoundary('{1'b0, 8'h00, 1'b1, 8'h10, 1'b0, 8'h00, 1'b0, 16'h0F55, 1'b1, 8'h10, 1'b0});
    waitDone();
    check("R11 access count", logCnt, 5);
    check("R2 acc0", {logWe[0], logAddr[0], logData[0]}, {1'b1, 20'h2FFFE, 16'h0F55});
    check("R2 acc1", {logWe[1], logAddr[1], logData[1]}, {1'b1, 20'h2FFFC, BASE_CS});
    check("R2 acc2", {logWe[2], logAddr[2], logData[2]}, {1'b1, 20'h2FFFA, BASE_IP});
    check("R2 acc3", {logWe[3], logAddr[3]}, {1'b0, 20'h00040});
    check("R2 acc4", {logWe[4], logAddr[4]}, {1'b0, 20'h00042});
    check("R2 sp", spOut, 16'hFFFA);
    check("R3 flags cleared", flagsOut, 16'h0C55);
    check("R11 ip", ipOut, vecWord(20'h00040));

    // R5: return from the frame just built
    clearLog(); stallCycles = 1;
    @(negedge clk);
    flagsIn = flagsOut; csIn = csOut; ipIn = ipOut; spIn = spOut; retReq = 1;
    @(negedge clk); retReq = 0;
    waitDone();
    check("R5 count", logCnt, 3);
    check("R5 order", {logAddr[0], logAddr[1], logAddr[2]}, {20'h2FFFA, 20'h2FFFC, 20'h2FFFE});
    check("R5 ip", ipOut, BASE_IP);
    check("R5 cs", csOut, BASE_CS);
    check("R5 flags", flagsOut, 16'h0F55);
    check("R5 sp", spOut, 16'h0000);
    check("R5 done", doneCnt, 1);

    // R12: return request together with a quiet boundary is dropped
    clearLog();
    @(negedge clk); flagsIn = 16'h0000; retReq = 1; instrDone = 1;
    @(negedge clk); retReq = 0; instrDone = 0;
    repeat (5) @(negedge clk);
    check("R12 dropped", reqCycles, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule